// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block forms the byte that a byte-wide flash device returns on a read while its internal program/erase engine is working. It combines the engine's busy flag, the type of operation, bit 7 of the byte being written, a verify-failure pulse, an erase-window flag and a suspend acknowledge into one status byte. It also drives a selector that puts this byte on the read path instead of array data while the engine is busy. The cell array and the real pulse timing are outside the block.

An operation whose target is protected does not occupy the engine. A start pulse for such an operation instead runs a short internal guard timer. While that timer runs, the status byte is shown as if an operation were in progress. When it expires, reads return array data again.

All flags are registered on the clock, so an input change shows on the outputs one cycle after the edge that samples it.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `status` is 0x88, `sel_status` is 0 and `dout` equals `array_data`.
- R2: For a program (`op_is_erase`=0 at start), bit 7 of `status` reads the inverse of the captured `prog_bit` while busy, and the captured `prog_bit` itself once the engine is idle.
- R3: For an erase (`op_is_erase`=1 at start), bit 7 reads 0 while busy and 1 once idle.
- R4: While status is selected, bit 6 inverts exactly once per rising edge of `rd_strobe`, however long the strobe is held high.
- R5: Bit 6 does not change while the block is idle or while an erase is suspended (`susp_ack`=1 during an erase). A suspended erase sets `sel_status` to 0, so `dout` carries array data.
- R6: Bit 5 becomes 1 the cycle after a `fail_pulse` and stays 1 until `clr_error`. `clr_error` wins when both arrive in the same cycle.
- R7: Bit 3 reads 0 during an erase while `window_open` is 1, reads 1 during an erase once `window_open` is 0, and reads 0 for a program.
- R8: Bits 4, 2, 1 and 0 of `status` are always 0 (mask 0x17).
- R9: A `prot_start` pulse given while idle shows busy status for exactly PROT_HOLD_CYCLES cycles and then returns to array data. A `prot_start` pulse given while busy has no effect.
- R10: `sel_status` is 1 exactly while the block is busy (engine or guard timer) and the operation is not a suspended erase. `dout` equals `status` when `sel_status` is 1 and `array_data` when it is 0.
- R11: The operation kind and `prog_bit` are captured only when an operation starts. Later changes to those inputs do not alter `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_busy | input | 1 | Program/erase engine busy |
| op_is_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_bit | input | 1 | Bit 7 of the byte being programmed |
| fail_pulse | input | 1 | Verify failure |
| clr_error | input | 1 | Reset command written; clears the error bit |
| window_open | input | 1 | Erase block-entry window still open |
| susp_ack | input | 1 | Erase suspend acknowledged |
| rd_strobe | input | 1 | Read strobe; rising edge is one read |
| prot_start | input | 1 | Start of an operation aimed at a protected area |
| array_data | input | 8 | Array read data |
| status | output | 8 | Status byte |
| dout | output | 8 | Read data: status or array data |
| sel_status | output | 1 | 1 when `dout` carries status |

## Verification
The bench holds the read strobe high for several cycles. A design that toggles on level rather than on edge would invert bit 6 more than once per read. It pulses reads while the engine is idle and while an erase is suspended, which catches a toggle that is not gated by the busy state. It changes `prog_bit` and the operation kind after the start, which exposes a design that tracks those inputs live instead of capturing them. It counts the exact length of the protected-target busy window, which detects an off-by-one guard counter. It also fires the protected start while the engine is busy, which catches a design that lets the timer restart. Finally, it raises fail and clear in the same cycle to pin down which one has priority.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int STAT_W   = 8;
    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;
    localparam int ERR_POS  = 5;
    localparam int WIN_POS  = 3;
    localparam logic [STAT_W-1:0] RESV_MASK = 8'h17;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic     eng;
        op_kind_e kind;
        logic     wbit;
        logic     err;
        logic     win;
        logic     susp;
    } core_st_t;

    typedef struct packed {
        logic strb;
        logic tog;
    } tog_st_t;
endpackage

// File: rtl/fsg_toggle.sv
module fsg_toggle
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic enable,
    output logic tog
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.strb = rd_strobe;
        if (rd_strobe && !st_q.strb && enable) begin
            st_d.tog = !st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog = st_q.tog;

    AST_TOG_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tog != $past(st_q.tog)) |-> $past(rd_strobe && !st_q.strb && enable)); // R4

    AST_TOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> $stable(st_q.tog)); // R5
endmodule

// File: rtl/fsg_guard_timer.sv
module fsg_guard_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD); // R9

    AST_GUARD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !fire) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/fsg_pack.sv
module fsg_pack
    import fsg_pkg::*;
(
    input  logic              show_busy,
    input  op_kind_e          kind,
    input  logic              wbit,
    input  logic              tog,
    input  logic              err,
    input  logic              win_open,
    output logic [STAT_W-1:0] stat
);
    always_comb begin
        stat = '0;
        if (kind == OP_ERASE) begin
            stat[POLL_POS] = !show_busy;
            stat[WIN_POS]  = !win_open;
        end else begin
            stat[POLL_POS] = show_busy ? !wbit : wbit;
            stat[WIN_POS]  = 1'b0;
        end
        stat[TOG_POS] = tog;
        stat[ERR_POS] = err;
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int PROT_HOLD_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_busy,
    input  logic       op_is_erase,
    input  logic       prog_bit,
    input  logic       fail_pulse,
    input  logic       clr_error,
    input  logic       window_open,
    input  logic       susp_ack,
    input  logic       rd_strobe,
    input  logic       prot_start,
    input  logic [7:0] array_data,
    output logic [7:0] status,
    output logic [7:0] dout,
    output logic       sel_status
);
    core_st_t st_d, st_q;
    logic guard_on;
    logic ind_busy;
    logic start_eng;
    logic prot_fire;
    logic tog_bit;

    assign ind_busy  = st_q.eng || guard_on;
    assign start_eng = eng_busy && !st_q.eng && !guard_on;
    assign prot_fire = prot_start && !ind_busy && !eng_busy;

    always_comb begin
        st_d      = st_q;
        st_d.eng  = eng_busy;
        st_d.win  = window_open;
        st_d.susp = susp_ack;
        if (start_eng || prot_fire) begin
            st_d.kind = op_kind_e'(op_is_erase);
            st_d.wbit = prog_bit;
        end
        if (clr_error) begin
            st_d.err = 1'b0;
        end else if (fail_pulse) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{eng: 1'b0, kind: OP_ERASE, wbit: 1'b0,
                      err: 1'b0, win: 1'b0, susp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_status = ind_busy && !((st_q.kind == OP_ERASE) && st_q.susp);

    fsg_guard_timer #(.CYCLES(PROT_HOLD_CYCLES)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (prot_fire),
        .active (guard_on)
    );

    fsg_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .enable    (sel_status),
        .tog       (tog_bit)
    );

    fsg_pack u_pack (
        .show_busy (ind_busy),
        .kind      (st_q.kind),
        .wbit      (st_q.wbit),
        .tog       (tog_bit),
        .err       (st_q.err),
        .win_open  (st_q.win),
        .stat      (status)
    );

    assign dout = sel_status ? status : array_data;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ERR_POS] && !clr_error) |=> status[ERR_POS]); // R6

    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_status) |-> (dout == array_data)); // R10

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_status && st_q.kind == OP_ERASE) |-> !dout[POLL_POS]); // R3

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & RESV_MASK) == '0); // R8
endmodule

// File: tb/tb_flash_status_gen.sv
`timescale 1ns/1ps
module tb_flash_status_gen;
    localparam int PROT = 20;

    logic clk = 1'b0;
    logic rst_n, eng_busy, op_is_erase, prog_bit, fail_pulse, clr_error;
    logic window_open, susp_ack, rd_strobe, prot_start;
    logic [7:0] array_data, status, dout;
    logic sel_status;

    always #5 clk = ~clk;

    flash_status_gen #(.PROT_HOLD_CYCLES(PROT)) dut (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .op_is_erase(op_is_erase),
        .prog_bit(prog_bit), .fail_pulse(fail_pulse), .clr_error(clr_error),
        .window_open(window_open), .susp_ack(susp_ack), .rd_strobe(rd_strobe),
        .prot_start(prot_start), .array_data(array_data), .status(status),
        .dout(dout), .sel_status(sel_status)
    );

    int total = 0;
    int bad = 0;
    bit running = 0;

    // behavioural reference state
    bit m_eng, m_kind, m_wbit, m_tog, m_err, m_strb, m_win, m_susp;
    int m_pcnt;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_busy();
        return m_eng || (m_pcnt > 0);
    endfunction

    function automatic bit m_sel();
        return m_busy() && !(m_kind && m_susp);
    endfunction

    function automatic logic [7:0] m_status();
        logic [7:0] s;
        s = 8'h00;
        s[7] = m_kind ? !m_busy() : (m_busy() ? !m_wbit : m_wbit);
        s[6] = m_tog;
        s[5] = m_err;
        s[3] = m_kind && !m_win;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_eng = 0; m_kind = 1; m_wbit = 0; m_tog = 0; m_err = 0;
            m_strb = 0; m_win = 0; m_susp = 0; m_pcnt = 0;
        end else begin
            bit was_busy, was_sel, fire;
            was_busy = m_busy();
            was_sel  = m_sel();
            fire = prot_start && !was_busy && !eng_busy;
            if ((eng_busy && !m_eng && m_pcnt == 0) || fire) begin
                m_kind = op_is_erase;
                m_wbit = prog_bit;
            end
            if (fire) m_pcnt = PROT;
            else if (m_pcnt > 0) m_pcnt--;
            if (rd_strobe && !m_strb && was_sel) m_tog = !m_tog;
            m_strb = rd_strobe;
            if (clr_error) m_err = 0;
            else if (fail_pulse) m_err = 1;
            m_eng = eng_busy;
            m_win = window_open;
            m_susp = susp_ack;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (running) begin
            logic [7:0] e;
            e = m_status();
            check(m_kind ? "R3 poll" : "R2 poll", {7'd0, status[7]}, {7'd0, e[7]});
            check("R4 toggle", {7'd0, status[6]}, {7'd0, e[6]});
            check("R6 error", {7'd0, status[5]}, {7'd0, e[5]});
            check("R7 window", {7'd0, status[3]}, {7'd0, e[3]});
            check("R8 reserved", status & 8'h17, 8'h00);
            check("R10 select", {7'd0, sel_status}, {7'd0, m_sel()});
            check("R10 dout", dout, m_sel() ? e : array_data);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_pulse();
        rd_strobe = 1; step(1); rd_strobe = 0; step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic t0;
        int n;
        rst_n = 0; eng_busy = 0; op_is_erase = 0; prog_bit = 0; fail_pulse = 0;
        clr_error = 0; window_open = 0; susp_ack = 0; rd_strobe = 0; prot_start = 0;
        array_data = 8'h5A;
        step(3);
        rst_n = 1;
        running = 1;
        @(negedge clk);
        check("R1 status", status, 8'h88);
        check("R1 sel", {7'd0, sel_status}, 8'h00);
        check("R1 dout", dout, 8'h5A);

        // program of a byte whose bit 7 is 1
        step(1); op_is_erase = 0; prog_bit = 1; eng_busy = 1;
        step(1); prog_bit = 0; op_is_erase = 1;
        @(negedge clk);
        check("R2 busy poll", {7'd0, status[7]}, 8'h00);
        check("R10 busy sel", {7'd0, sel_status}, 8'h01);
        step(2);
        @(negedge clk);
        check("R11 late inputs", {7'd0, status[7], status[3]}, 8'h00);
        t0 = status[6];
        step(1); read_pulse();
        @(negedge clk);
        check("R4 one read", {7'd0, status[6]}, {7'd0, !t0});
        step(1); rd_strobe = 1; step(4); rd_strobe = 0; step(1);
        @(negedge clk);
        check("R4 held strobe", {7'd0, status[6]}, {7'd0, t0});
        step(1); eng_busy = 0; step(1);
        @(negedge clk);
        check("R2 done poll", {7'd0, status[7]}, 8'h01);
        check("R10 idle dout", dout, 8'h5A);
        t0 = status[6];
        step(1); read_pulse(); array_data = 8'hC3;
        @(negedge clk);
        check("R5 idle toggle", {7'd0, status[6]}, {7'd0, t0});
        check("R10 idle dout2", dout, 8'hC3);

        // erase
        step(1); op_is_erase = 1; window_open = 1; eng_busy = 1; step(1);
        @(negedge clk);
        check("R3 busy poll", {7'd0, status[7]}, 8'h00);
        check("R7 window open", {7'd0, status[3]}, 8'h00);
        step(1); window_open = 0; step(1);
        @(negedge clk);
        check("R7 window shut", {7'd0, status[3]}, 8'h01);
        step(1); susp_ack = 1; step(1);
        @(negedge clk);
        check("R5 suspend sel", {7'd0, sel_status}, 8'h00);
        check("R5 suspend dout", dout, 8'hC3);
        t0 = status[6];
        step(1); read_pulse();
        @(negedge clk);
        check("R5 suspend toggle", {7'd0, status[6]}, {7'd0, t0});
        step(1); susp_ack = 0; fail_pulse = 1; step(1); fail_pulse = 0;
        @(negedge clk);
        check("R6 set", {7'd0, status[5]}, 8'h01);
        t0 = status[6];
        step(1); read_pulse();
        @(negedge clk);
        check("R4 erase read", {7'd0, status[6]}, {7'd0, !t0});
        step(1); eng_busy = 0; step(3);
        @(negedge clk);
        check("R3 done poll", {7'd0, status[7]}, 8'h01);
        check("R6 sticky", {7'd0, status[5]}, 8'h01);
        step(1); clr_error = 1; fail_pulse = 1; step(1); clr_error = 0; fail_pulse = 0;
        @(negedge clk);
        check("R6 clear wins", {7'd0, status[5]}, 8'h00);

        // protected target
        step(1); op_is_erase = 0; prog_bit = 1; prot_start = 1; step(1); prot_start = 0;
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            if (!sel_status) break;
            n++;
        end
        check("R9 hold length", 8'(n), 8'(PROT));
        check("R9 back to array", dout, 8'hC3);
        step(1); eng_busy = 1; step(1); prot_start = 1; step(1); prot_start = 0;
        eng_busy = 0; step(2);
        @(negedge clk);
        check("R9 ignored busy", {7'd0, sel_status}, 8'h00);
        check("R8 reserved", status & 8'h17, 8'h00);

        step(2);
        running = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule